// File: doc/BRIEF.md
# Character-Cell On-Screen-Display Pixel Generator

This block paints an on-screen-display overlay for a monitor. The screen area it owns is a grid of 30 character columns by 15 character rows. Each cell is a 16-bit word in an external display RAM that names a glyph and a foreground colour. Column 30 of every RAM row holds a row word that sets the background colour, the intensity bits, the character scale (1x to 4x, set separately for width and height) and a blank mode. Glyphs are 12 dots wide and 18 lines tall, and they come from an external font read port that returns one dot row per access.

All timing is recovered from the active-low horizontal and vertical flyback inputs. A falling edge on horizontal flyback starts a new line. A falling edge on vertical flyback starts a new frame. Two input ports place the character grid on the line and in the frame. The block produces red, green and blue levels, an intensity bit and a fast-blank bit. The video mixer downstream uses fast blank to switch the overlay in over the picture. The RAM and font reads form a two-stage pipeline. Every output therefore lags its pixel counter by exactly two clocks, and the horizontal offset absorbs this lag.

Top module: `osd_char_gen`

## Requirements
- R1: After reset, and on every pixel outside the 30x15 cell area, r_o, g_o, b_o, int_o and fblk_o are all 0.
- R2: Pixel index k is the k-th clock after the clock that first samples hflb_n low following a high sample (that clock is index 0). Column 0, dot 0 of the grid is pixel index h_start, with h_start of at least 2. Every falling edge restarts the count at 0.
- R3: The line that contains the clock sampling vflb_n low after a high sample is line 0, and each later horizontal falling edge adds one. Grid row 0, font line 0 is shown on line v_start. If both edges arrive together, the vertical one wins.
- R4: The cell read address is {row[3:0], col[4:0]} and the row-word read address is {row[3:0], 5'd30}. Both read ports return data one clock after the address.
- R5: The font read address is {glyph[7:0], font_line[4:0]}. Data returns one clock later, 12 bits wide, and bit 11 is the leftmost dot.
- R6: Cell word: bits 7..0 select the glyph and bits 11..8 give the foreground colour (bit 11 intensity, bits 10, 9, 8 = R, G, B). Bits 15..12 have no effect on any output.
- R7: Row word: bits 3..0 give the background colour (same encoding as R6), bit 4 raster intensity, bit 5 character intensity, bits 7..6 horizontal size code, bits 9..8 vertical size code, bit 10 blank mode. Bits 15..11 have no effect.
- R8: A foreground dot drives R, G, B from the cell colour, int_o = colour bit 3 OR character intensity, and fblk_o = 1. A background dot drives R, G, B from the row colour, int_o = colour bit 3 OR raster intensity, and fblk_o = 1. When blank mode is set, a background dot drives all five outputs to 0.
- R9: A horizontal size code s repeats each dot for s+1 consecutive pixels, so a row is 360*(s+1) pixels wide.
- R10: A vertical size code s repeats each font line on s+1 consecutive lines, so the row is 18*(s+1) lines tall. The next row starts on the line after that.
- R11: The output for pixel k appears in clock k+2: two clocks after the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hflb_n | input | 1 | Horizontal flyback, active low |
| vflb_n | input | 1 | Vertical flyback, active low |
| h_start | input | 11 | Pixel index of the grid's first dot |
| v_start | input | 11 | Line index of the grid's first line |
| cell_addr | output | 9 | Display RAM cell read address |
| cell_data | input | 16 | Cell word, one clock after cell_addr |
| rattr_addr | output | 9 | Display RAM row-word read address |
| rattr_data | input | 16 | Row word, one clock after rattr_addr |
| font_addr | output | 13 | Font read address |
| font_data | input | 12 | Font dot row, one clock after font_addr |
| r_o | output | 1 | Red |
| g_o | output | 1 | Green |
| b_o | output | 1 | Blue |
| int_o | output | 1 | Intensity |
| fblk_o | output | 1 | Fast blank, overlay select |

## Verification
The assertions check several rules on every cycle. Each horizontal and vertical falling edge must restart the counters that follow it. The column and row indices must stay inside the grid and the dot and font-line indices inside the glyph. Fast blank must never be high unless the counters marked that pixel as inside the grid two clocks earlier. Whenever fast blank is low, the colour and intensity outputs must be dark. Other behaviour shows only in the bench's scenarios: that the right cell, glyph line and dot reach each pixel, the colour choice between foreground and background with its intensity OR, the 1x to 4x scaling of width and height row by row, the blank mode, and the ignored spare bits. For these the bench compares every captured pixel with a model computed by division from the frame geometry.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int COLS    = 30;
  localparam int ROWS    = 15;
  localparam int FONT_W  = 12;
  localparam int FONT_H  = 18;
  localparam int GLYPH_W = 8;
  localparam int WORD_W  = 16;
  localparam int RATTR_COL = 30;
  localparam int COL_W   = $clog2(COLS + 1);
  localparam int ROW_W   = $clog2(ROWS + 1);
  localparam int LINE_W  = $clog2(FONT_H);
  localparam int DOT_W   = $clog2(FONT_W);
  localparam int RAM_AW  = ROW_W + COL_W;
  localparam int ROM_AW  = GLYPH_W + LINE_W;

  typedef struct packed {
    logic [4:0] spare;
    logic       blank;
    logic [1:0] vsize;
    logic [1:0] hsize;
    logic       chr_int;
    logic       ras_int;
    logic [3:0] ras_col;
  } row_word_t;

  typedef struct packed {
    logic       blank;
    logic       chr_int;
    logic       ras_int;
    logic [3:0] ras_col;
  } pix_attr_t;
endpackage

// File: rtl/osd_htiming.sv
module osd_htiming #(
  parameter int CNT_W = 11,
  parameter int NCOL  = 30,
  parameter int GW    = 12,
  localparam int CW   = $clog2(NCOL + 1),
  localparam int DW   = $clog2(GW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hflb_n,
  input  logic [CNT_W-1:0] h_start,
  input  logic [1:0]       hsize,
  output logic             hfall,
  output logic             h_on,
  output logic [CW-1:0]    col,
  output logic [DW-1:0]    dot
);
  logic             hflb_q;
  logic [CNT_W-1:0] hcnt, hcnt_n;
  logic [CW-1:0]    col_n;
  logic [DW-1:0]    dot_n;
  logic [1:0]       hrep, hrep_n;

  assign hfall = hflb_q & ~hflb_n;
  assign h_on  = (hcnt >= h_start) && (col < CW'(NCOL));

  always_comb begin
    hcnt_n = (hcnt == {CNT_W{1'b1}}) ? hcnt : hcnt + CNT_W'(1);
    col_n  = col;
    dot_n  = dot;
    hrep_n = hrep;
    if (hfall) begin
      hcnt_n = '0;
      col_n  = '0;
      dot_n  = '0;
      hrep_n = '0;
    end else if (h_on) begin
      if (hrep == hsize) begin
        hrep_n = '0;
        if (dot == DW'(GW - 1)) begin
          dot_n = '0;
          col_n = col + CW'(1);
        end else begin
          dot_n = dot + DW'(1);
        end
      end else begin
        hrep_n = hrep + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hflb_q <= 1'b1;
      hcnt   <= '1;
      col    <= CW'(NCOL);
      dot    <= '0;
      hrep   <= '0;
    end else begin
      hflb_q <= hflb_n;
      hcnt   <= hcnt_n;
      col    <= col_n;
      dot    <= dot_n;
      hrep   <= hrep_n;
    end
  end

  assert_line_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hfall |=> (hcnt == '0 && col == '0 && dot == '0 && hrep == '0))
    else $error("line restart missed");

  assert_col_in_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (col <= CW'(NCOL)) && (dot < DW'(GW)))
    else $error("column or dot out of range");
endmodule

// File: rtl/osd_vtiming.sv
module osd_vtiming #(
  parameter int CNT_W = 11,
  parameter int NROW  = 15,
  parameter int GH    = 18,
  localparam int RW   = $clog2(NROW + 1),
  localparam int LW   = $clog2(GH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vflb_n,
  input  logic             hfall,
  input  logic [CNT_W-1:0] v_start,
  input  logic [1:0]       vsize,
  output logic             v_on,
  output logic [RW-1:0]    row,
  output logic [LW-1:0]    fline
);
  logic             vflb_q, vfall;
  logic [CNT_W-1:0] vcnt, vcnt_n;
  logic [RW-1:0]    row_n;
  logic [LW-1:0]    fline_n;
  logic [1:0]       vrep, vrep_n;

  assign vfall = vflb_q & ~vflb_n;
  assign v_on  = (vcnt >= v_start) && (row < RW'(NROW));

  always_comb begin
    vcnt_n  = vcnt;
    row_n   = row;
    fline_n = fline;
    vrep_n  = vrep;
    if (vfall) begin
      vcnt_n  = '0;
      row_n   = '0;
      fline_n = '0;
      vrep_n  = '0;
    end else if (hfall) begin
      vcnt_n = (vcnt == {CNT_W{1'b1}}) ? vcnt : vcnt + CNT_W'(1);
      if (v_on) begin
        if (vrep == vsize) begin
          vrep_n = '0;
          if (fline == LW'(GH - 1)) begin
            fline_n = '0;
            row_n   = row + RW'(1);
          end else begin
            fline_n = fline + LW'(1);
          end
        end else begin
          vrep_n = vrep + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vflb_q <= 1'b1;
      vcnt   <= '1;
      row    <= RW'(NROW);
      fline  <= '0;
      vrep   <= '0;
    end else begin
      vflb_q <= vflb_n;
      vcnt   <= vcnt_n;
      row    <= row_n;
      fline  <= fline_n;
      vrep   <= vrep_n;
    end
  end

  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vfall |=> (vcnt == '0 && row == '0 && fline == '0))
    else $error("frame restart missed");

  assert_row_in_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (row <= RW'(NROW)) && (fline < LW'(GH)))
    else $error("row or font line out of range");
endmodule

// File: rtl/osd_pixel.sv
module osd_pixel
  import osd_pkg::*;
#(
  parameter int GW = 12,
  parameter int LW = 5,
  parameter int GLW = 8,
  parameter int WW = 16,
  localparam int DW = $clog2(GW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           act0,
  input  logic [DW-1:0]  dot0,
  input  logic [LW-1:0]  fline0,
  input  row_word_t      rw0,
  input  logic [WW-1:0]  cell_q,
  input  logic [GW-1:0]  font_q,
  output logic [GLW+LW-1:0] font_addr,
  output logic           r,
  output logic           g,
  output logic           b,
  output logic           inten,
  output logic           fblk
);
  logic          act1, act2;
  logic [DW-1:0] dot1, dot2;
  logic [LW-1:0] fline1;
  pix_attr_t     pa1, pa2;
  logic [3:0]    fg2;
  logic          dot_on;

  assign font_addr = {cell_q[GLW-1:0], fline1};
  assign dot_on    = font_q[DW'(GW - 1) - dot2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act1 <= 1'b0; act2 <= 1'b0;
      dot1 <= '0;   dot2 <= '0;
      fline1 <= '0;
      pa1 <= '0;    pa2 <= '0;
      fg2 <= '0;
    end else begin
      act1   <= act0;
      dot1   <= dot0;
      fline1 <= fline0;
      pa1    <= '{blank: rw0.blank, chr_int: rw0.chr_int,
                  ras_int: rw0.ras_int, ras_col: rw0.ras_col};
      act2   <= act1;
      dot2   <= dot1;
      pa2    <= pa1;
      fg2    <= cell_q[GLW+3:GLW];
    end
  end

  always_comb begin
    {r, g, b} = 3'b000;
    inten = 1'b0;
    fblk  = 1'b0;
    if (act2) begin
      if (dot_on) begin
        {r, g, b} = fg2[2:0];
        inten = fg2[3] | pa2.chr_int;
        fblk  = 1'b1;
      end else if (!pa2.blank) begin
        {r, g, b} = pa2.ras_col[2:0];
        inten = pa2.ras_col[3] | pa2.ras_int;
        fblk  = 1'b1;
      end
    end
  end

  assert_dark_when_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fblk |-> ({r, g, b, inten} == 4'b0000))
    else $error("colour driven without fast blank");
endmodule

// File: rtl/osd_char_gen.sv
module osd_char_gen
  import osd_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hflb_n,
  input  logic              vflb_n,
  input  logic [CNT_W-1:0]  h_start,
  input  logic [CNT_W-1:0]  v_start,
  output logic [RAM_AW-1:0] cell_addr,
  input  logic [WORD_W-1:0] cell_data,
  output logic [RAM_AW-1:0] rattr_addr,
  input  logic [WORD_W-1:0] rattr_data,
  output logic [ROM_AW-1:0] font_addr,
  input  logic [FONT_W-1:0] font_data,
  output logic              r_o,
  output logic              g_o,
  output logic              b_o,
  output logic              int_o,
  output logic              fblk_o
);
  logic [1:0]        rsync;
  logic              rst_n_s;
  logic              hfall, h_on, v_on, act0;
  logic [COL_W-1:0]  col;
  logic [DOT_W-1:0]  dot;
  logic [ROW_W-1:0]  row;
  logic [LINE_W-1:0] fline;
  row_word_t         rw;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_n_s = rsync[1];

  assign rw          = row_word_t'(rattr_data);
  assign unused_bits = ^{rw.spare, cell_data[WORD_W-1:GLYPH_W+4]};
  assign act0        = h_on & v_on;
  assign cell_addr   = {row, col};
  assign rattr_addr  = {row, COL_W'(RATTR_COL)};

  osd_htiming #(.CNT_W(CNT_W), .NCOL(COLS), .GW(FONT_W)) u_h (
    .clk(clk), .rst_n(rst_n_s), .hflb_n(hflb_n), .h_start(h_start),
    .hsize(rw.hsize), .hfall(hfall), .h_on(h_on), .col(col), .dot(dot));

  osd_vtiming #(.CNT_W(CNT_W), .NROW(ROWS), .GH(FONT_H)) u_v (
    .clk(clk), .rst_n(rst_n_s), .vflb_n(vflb_n), .hfall(hfall),
    .v_start(v_start), .vsize(rw.vsize), .v_on(v_on), .row(row), .fline(fline));

  osd_pixel #(.GW(FONT_W), .LW(LINE_W), .GLW(GLYPH_W), .WW(WORD_W)) u_p (
    .clk(clk), .rst_n(rst_n_s), .act0(act0), .dot0(dot), .fline0(fline),
    .rw0(rw), .cell_q(cell_data), .font_q(font_data), .font_addr(font_addr),
    .r(r_o), .g(g_o), .b(b_o), .inten(int_o), .fblk(fblk_o));

  assert_two_clock_lag_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    fblk_o |-> $past(act0, 2))
    else $error("overlay without an in-grid pixel two clocks earlier");

  assert_cell_addr_in_grid_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    act0 |-> (cell_addr[COL_W-1:0] < COL_W'(COLS) && cell_addr[RAM_AW-1:COL_W] < ROW_W'(ROWS)))
    else $error("cell address outside grid");
endmodule

// File: tb/sim_osd_char_gen.sv
`timescale 1ns/1ps
module sim_osd_char_gen;
  localparam int WD = 180000;
  logic clk = 1'b0;
  logic rst_n, hflb_n, vflb_n;
  logic [10:0] h_start, v_start;
  logic [8:0]  cell_addr, rattr_addr;
  logic [15:0] cell_data, rattr_data;
  logic [12:0] font_addr;
  logic [11:0] font_data;
  logic r_o, g_o, b_o, int_o, fblk_o;

  logic [15:0] mem [0:511];
  logic [4:0]  cap [0:1199];
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  osd_char_gen u0 (.clk(clk), .rst_n(rst_n), .hflb_n(hflb_n), .vflb_n(vflb_n),
    .h_start(h_start), .v_start(v_start), .cell_addr(cell_addr), .cell_data(cell_data),
    .rattr_addr(rattr_addr), .rattr_data(rattr_data), .font_addr(font_addr),
    .font_data(font_data), .r_o(r_o), .g_o(g_o), .b_o(b_o), .int_o(int_o), .fblk_o(fblk_o));

  function automatic logic [11:0] romf(input logic [12:0] a);
    return {a[12:5], a[3:0]} ^ {3'b000, a[4:0], a[12:9]};
  endfunction

  // R4/R5: synchronous read ports
  always @(posedge clk) begin
    cell_data  <= mem[cell_addr];
    rattr_data <= mem[rattr_addr];
    font_data  <= romf(font_addr);
  end

  // expected {fblk,int,r,g,b} for line ln, pixel k, computed by division
  function automatic logic [4:0] expect_px(input int ln, input int k);
    int y, x, r, vs, hs, fl, c, d;
    logic [15:0] rw, cw;
    logic [11:0] bits;
    y = ln - int'(v_start);
    if (y < 0) return 5'b0;
    r = 0;
    while (r < 15) begin
      rw = mem[r*32 + 30];
      vs = int'(rw[9:8]) + 1;
      if (y < 18*vs) break;
      y -= 18*vs;
      r++;
    end
    if (r >= 15) return 5'b0;
    fl = y / vs;
    hs = int'(rw[7:6]) + 1;
    x = k - int'(h_start);
    if (x < 0 || x >= 360*hs) return 5'b0;
    c = x / (12*hs);
    d = (x % (12*hs)) / hs;
    cw = mem[r*32 + c];
    bits = romf({cw[7:0], 5'(fl)});
    if (bits[11-d]) return {1'b1, cw[11] | rw[5], cw[10:8]};
    if (rw[10]) return 5'b0;
    return {1'b1, rw[3] | rw[4], rw[2:0]};
  endfunction

  task automatic chk(input logic [4:0] got, input logic [4:0] exp, input string tag,
                     input int ln, input int k);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s line %0d px %0d: actual %b expected %b", tag, ln, k, got, exp);
    end
  endtask

  task automatic run_line(input bit frame, input int len);
    @(negedge clk);
    hflb_n = 1'b0;
    vflb_n = frame ? 1'b0 : 1'b1;
    @(negedge clk);
    cap[0] = {fblk_o, int_o, r_o, g_o, b_o};
    hflb_n = 1'b1;
    vflb_n = 1'b1;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      cap[i] = {fblk_o, int_o, r_o, g_o, b_o};
    end
  endtask

  task automatic run_frame(input int len, input int nlines, input string tag);
    for (int ln = 0; ln < nlines; ln++) begin
      run_line(ln == 0, len);
      for (int k = 0; k + 2 < len; k++) chk(cap[k+2], expect_px(ln, k), tag, ln, k);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 512; i++) mem[i] = 16'(i * 40503 + seed * 7919);
  endtask

  task automatic set_row(input int r, input logic blank, input logic [1:0] vs,
                         input logic [1:0] hs, input logic [5:0] col_int);
    mem[r*32 + 30] = {5'b10101, blank, vs, hs, col_int};
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({fblk_o, int_o, r_o, g_o, b_o}, 5'b0, "R1 reset", -1, i);
    end
  endtask

  task automatic t_plain_line;
    fill(1);
    for (int r = 0; r < 15; r++) set_row(r, 1'b0, 2'd0, 2'd0, 6'(r * 11));
    h_start = 11'd4; v_start = 11'd0;
    run_frame(372, 2, "R2 R4 R5 R6 R8 R11 R1");
  endtask

  task automatic t_scaled_frame;
    int total;
    fill(2);
    total = 0;
    for (int r = 0; r < 15; r++) begin
      set_row(r, (r % 3) == 0, 2'((r + 1) % 4), 2'(r % 4), 6'(r * 23 + 5));
      total += 18 * ((r + 1) % 4 + 1);
    end
    h_start = 11'd5; v_start = 11'd3;
    run_frame(48, total + 3 + 2, "R3 R7 R8 R9 R10 R1");
  endtask

  task automatic t_wide_row;
    fill(3);
    for (int r = 0; r < 15; r++) set_row(r, r[0], 2'd0, 2'd2, 6'(r * 7));
    h_start = 11'd2; v_start = 11'd0;
    run_frame(1092, 1, "R9 R2 R1");
  endtask

  task automatic t_spare_bits;
    fill(1);
    for (int r = 0; r < 15; r++) set_row(r, 1'b0, 2'd0, 2'd0, 6'(r * 11));
    for (int i = 0; i < 512; i++) mem[i][15:12] = ~mem[i][15:12];
    h_start = 11'd4; v_start = 11'd0;
    run_frame(372, 1, "R6 R7 spare bits");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    rst_n = 1'b0; hflb_n = 1'b1; vflb_n = 1'b1;
    h_start = 11'd4; v_start = 11'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_line();
    t_scaled_frame();
    t_wide_row();
    t_spare_bits();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule